// File: doc/BRIEF.md
# Port Pin Function Priority Multiplexer

This block sits between the general-purpose registers of an 8-bit I/O port and its pads. For every pin it decides which source owns the pin in the current cycle: a timer output-compare channel, a maskable or non-maskable interrupt input, or the general-purpose data and direction bits. From that decision it produces the value driven onto the pad and its output-enable. The pad input value is always passed back for reading.

The priority order depends on a static package-option code. On the small package the timer does not reach pins 2 and 3. On the largest package the two interrupt inputs are not bonded out, so pins 0 and 1 are shared only between the timer and general-purpose I/O. The non-maskable interrupt pin turns into an input the first time the CPU clears its mask bit. It stays an input from then on, until a synchronous reset clears it.

Top module: `port_pin_arbiter`

## Requirements
- R1: After the synchronous active-low reset, with the NMI mask bit held at 1 and no timer or interrupt enable set, every pin drives its general-purpose data bit and its output-enable equals its general-purpose direction bit.
- R2: While timer channel 4's compare enable is 1, pin 4 has output-enable 1 and drives the channel 4 level on every package code.
- R3: On package codes 1, 2 and 3, an enabled timer channel 2 or 3 takes pin 2 or 3 (output-enable 1, timer level). On package code 0 those pins always follow the general-purpose bits.
- R4: On package codes other than 2, a maskable interrupt enable of 1 forces pin 1 to input (output-enable 0, output 0), whatever the timer or general-purpose settings.
- R5: On package code 2 the maskable interrupt enable is ignored on pin 1. An enabled timer channel 1 drives that pin, and otherwise the general-purpose bits do.
- R6: A lock flag is set at the first clock edge that samples the NMI mask at 0 after it was 1 (the mask counts as 1 just after reset). From the following cycle, on package codes other than 2, pin 0 has output-enable 0 and output 0, overriding timer channel 0. Before the lock, timer channel 0 has priority over the general-purpose bits on pin 0.
- R7: The lock stays set when the NMI mask returns to 1 and is cleared only by reset.
- R8: On package code 2 the lock has no effect on pin 0. Timer channel 0 and then the general-purpose bits drive it.
- R9: Pins 5, 6 and 7 always follow the general-purpose data and direction bits.
- R10: The read-back value equals the pad input on all pins, in every mode.
- R11: Package code 3 behaves exactly like code 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pkg_sel | input | 2 | Static package code: 0 small, 1 medium, 2 largest, 3 treated as medium |
| gp_data | input | 8 | General-purpose output data per pin |
| gp_dir | input | 8 | General-purpose direction per pin (1 = output) |
| tmr_oc_en | input | 5 | Output-compare enable of timer channels 0 to 4 |
| tmr_lvl | input | 5 | Output-compare level of timer channels 0 to 4 |
| mirq_en | input | 1 | Maskable interrupt pin enable |
| nmi_mask | input | 1 | CPU non-maskable interrupt mask bit |
| pad_in | input | 8 | Pad input values |
| pin_out | output | 8 | Value driven to each pad |
| pin_oe | output | 8 | Output-enable per pad |
| pin_rd | output | 8 | Read-back input value per pin |

## Verification
On pin 0, the sticky interrupt lock and an enabled timer channel 0 can both claim the pin in the same cycle. The bench enables timer channel 0 with level 1 and then drops the NMI mask. It checks that pin 0 still carries the timer level in the cycle where the mask first reads 0, and that it becomes an input with output 0 in the cycle after. On pin 1, the maskable interrupt and timer channel 1 are enabled together under several package codes. Each result is judged against the priority order that the package code selects.

// File: rtl/port_mux_pkg.sv
package port_mux_pkg;

    typedef enum logic [1:0] {
        PKG_SMALL  = 2'd0,
        PKG_MEDIUM = 2'd1,
        PKG_LARGE  = 2'd2
    } pkg_kind_e;

    // pins whose timer channel is not bonded on the small package
    localparam int GAP_LO = 2;
    localparam int GAP_HI = 3;

    typedef struct packed {
        logic mask_prev;
        logic locked;
    } lock_state_t;

    function automatic pkg_kind_e decode_pkg(input logic [1:0] code);
        pkg_kind_e k;
        case (code)
            2'd0:    k = PKG_SMALL;
            2'd2:    k = PKG_LARGE;
            default: k = PKG_MEDIUM;
        endcase
        return k;
    endfunction

    function automatic logic tmr_bonded(input int pin, input pkg_kind_e k);
        return !((k == PKG_SMALL) && (pin >= GAP_LO) && (pin <= GAP_HI));
    endfunction

endpackage

// File: rtl/nmi_lock.sv
module nmi_lock
    import port_mux_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_mask,
    output logic locked
);

    lock_state_t st_d, st_q;
    logic        fall_seen;

    always_comb begin
        st_d           = st_q;
        fall_seen      = st_q.mask_prev && !nmi_mask;
        st_d.mask_prev = nmi_mask;
        st_d.locked    = st_q.locked || fall_seen;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mask_prev <= 1'b1;
            st_q.locked    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign locked = st_q.locked;

    // R6
    lock_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mask_prev && !nmi_mask) |=> locked);

    // R7
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);

    // R6
    lock_no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && nmi_mask) |=> !locked);

endmodule

// File: rtl/pin_resolver.sv
module pin_resolver (
    input  logic force_in,
    input  logic tmr_claim,
    input  logic tmr_lvl,
    input  logic gp_d,
    input  logic gp_dir,
    output logic out,
    output logic oe
);

    always_comb begin
        if (force_in) begin
            out = 1'b0;
            oe  = 1'b0;
        end else if (tmr_claim) begin
            out = tmr_lvl;
            oe  = 1'b1;
        end else begin
            out = gp_d;
            oe  = gp_dir;
        end
    end

endmodule

// File: rtl/port_pin_arbiter.sv
module port_pin_arbiter
    import port_mux_pkg::*;
#(
    parameter int PINS    = 8,
    parameter int TMR_CH  = 5,
    parameter int IRQ_PIN = 1,
    parameter int NMI_PIN = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        pkg_sel,
    input  logic [PINS-1:0]   gp_data,
    input  logic [PINS-1:0]   gp_dir,
    input  logic [TMR_CH-1:0] tmr_oc_en,
    input  logic [TMR_CH-1:0] tmr_lvl,
    input  logic              mirq_en,
    input  logic              nmi_mask,
    input  logic [PINS-1:0]   pad_in,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_oe,
    output logic [PINS-1:0]   pin_rd
);

    pkg_kind_e       kind;
    logic            nmi_locked;
    logic            irq_bonded;
    logic [PINS-1:0] force_in;
    logic [PINS-1:0] tmr_claim;
    logic [PINS-1:0] lvl_map;

    assign kind       = decode_pkg(pkg_sel);
    assign irq_bonded = (kind != PKG_LARGE);

    nmi_lock u_nmi_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .nmi_mask (nmi_mask),
        .locked   (nmi_locked)
    );

    for (genvar p = 0; p < PINS; p++) begin : g_pin
        if (p < TMR_CH) begin : g_tmr
            assign tmr_claim[p] = tmr_oc_en[p] && tmr_bonded(p, kind);
            assign lvl_map[p]   = tmr_lvl[p];
        end else begin : g_plain
            assign tmr_claim[p] = 1'b0;
            assign lvl_map[p]   = 1'b0;
        end

        if (p == IRQ_PIN) begin : g_irq
            assign force_in[p] = irq_bonded && mirq_en;
        end else if (p == NMI_PIN) begin : g_nmi
            assign force_in[p] = irq_bonded && nmi_locked;
        end else begin : g_free
            assign force_in[p] = 1'b0;
        end

        pin_resolver u_res (
            .force_in  (force_in[p]),
            .tmr_claim (tmr_claim[p]),
            .tmr_lvl   (lvl_map[p]),
            .gp_d      (gp_data[p]),
            .gp_dir    (gp_dir[p]),
            .out       (pin_out[p]),
            .oe        (pin_oe[p])
        );
    end

    assign pin_rd = pad_in;

    // R2
    pin4_tmr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_oc_en[4] |-> (pin_oe[4] && (pin_out[4] == tmr_lvl[4])));

    // R3
    small_pkg_gp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkg_sel == 2'd0) |-> ((pin_oe[3:2] == gp_dir[3:2]) && (pin_out[3:2] == gp_data[3:2])));

    // R4
    irq_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mirq_en && (pkg_sel != 2'd2)) |-> (!pin_oe[IRQ_PIN] && !pin_out[IRQ_PIN]));

    // R6
    nmi_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_locked && (pkg_sel != 2'd2)) |-> (!pin_oe[NMI_PIN] && !pin_out[NMI_PIN]));

    // R9
    plain_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe[7:5] == gp_dir[7:5]) && (pin_out[7:5] == gp_data[7:5]));

endmodule

// File: tb/test_port_pin_arbiter.sv
module test_port_pin_arbiter;

    localparam int CLK_P = 10;

    typedef struct packed {
        logic [1:0] pkg;
        logic       mirq;
        logic [4:0] oc;
        logic [4:0] lvl;
        logic [7:0] gd;
        logic [7:0] gdir;
        logic [7:0] pad;
        logic [7:0] eout;
        logic [7:0] eoe;
    } vec_t;

    // R9 R10 base, R2/R3 timer, R3 small, R4 irq, R5 large, R11 code 3, R4 small
    localparam vec_t VECS [0:6] = '{
        '{2'd1, 1'b0, 5'h00, 5'h00, 8'hA5, 8'h3C, 8'h5A, 8'hA5, 8'h3C},
        '{2'd1, 1'b0, 5'h1F, 5'h15, 8'h00, 8'h00, 8'hC3, 8'h15, 8'h1F},
        '{2'd0, 1'b0, 5'h1F, 5'h0C, 8'hFF, 8'hE0, 8'h00, 8'hEC, 8'hF3},
        '{2'd1, 1'b1, 5'h1F, 5'h1F, 8'hFF, 8'hFF, 8'h81, 8'hFD, 8'hFD},
        '{2'd2, 1'b1, 5'h02, 5'h02, 8'h00, 8'h00, 8'h7E, 8'h02, 8'h02},
        '{2'd3, 1'b1, 5'h0C, 5'h08, 8'h01, 8'h03, 8'h33, 8'h09, 8'h0D},
        '{2'd0, 1'b1, 5'h00, 5'h00, 8'h02, 8'h02, 8'hF0, 8'h00, 8'h00}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] pkg_sel = 2'd1;
    logic [7:0] gp_data = '0;
    logic [7:0] gp_dir = '0;
    logic [4:0] tmr_oc_en = '0;
    logic [4:0] tmr_lvl = '0;
    logic       mirq_en = 1'b0;
    logic       nmi_mask = 1'b1;
    logic [7:0] pad_in = '0;
    logic [7:0] pin_out, pin_oe, pin_rd;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    port_pin_arbiter i_port_pin_arbiter (
        .clk       (clk),
        .rst_n     (rst_n),
        .pkg_sel   (pkg_sel),
        .gp_data   (gp_data),
        .gp_dir    (gp_dir),
        .tmr_oc_en (tmr_oc_en),
        .tmr_lvl   (tmr_lvl),
        .mirq_en   (mirq_en),
        .nmi_mask  (nmi_mask),
        .pad_in    (pad_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .pin_rd    (pin_rd)
    );

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R1 actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        gp_data = 8'h96;
        gp_dir  = 8'h69;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
        check8("R1 out after reset", pin_out, 8'h96);
        check8("R1 oe after reset", pin_oe, 8'h69);

        for (int i = 0; i < 7; i++) begin
            @(negedge clk);
            pkg_sel   = VECS[i].pkg;
            mirq_en   = VECS[i].mirq;
            tmr_oc_en = VECS[i].oc;
            tmr_lvl   = VECS[i].lvl;
            gp_data   = VECS[i].gd;
            gp_dir    = VECS[i].gdir;
            pad_in    = VECS[i].pad;
            #1;
            check8("R2 R3 R4 R5 R9 R11 table out", pin_out, VECS[i].eout);
            check8("R2 R3 R4 R5 R9 R11 table oe", pin_oe, VECS[i].eoe);
            check8("R10 table readback", pin_rd, VECS[i].pad);
        end

        // R6: timer 0 vs lock on pin 0
        @(negedge clk);
        pkg_sel = 2'd1; mirq_en = 1'b0;
        tmr_oc_en = 5'h01; tmr_lvl = 5'h01;
        gp_data = 8'h00; gp_dir = 8'h00; pad_in = 8'hA0;
        #1;
        check8("R6 timer0 before lock", {pin_oe[0], pin_out[0]}, 8'h03);
        @(negedge clk);
        nmi_mask = 1'b0;
        #1;
        check8("R6 same cycle as mask fall", {pin_oe[0], pin_out[0]}, 8'h03);
        settle();
        check8("R6 locked over timer0", {pin_oe[0], pin_out[0]}, 8'h00);
        check8("R10 readback while locked", pin_rd, 8'hA0);

        // R7: sticky
        @(negedge clk);
        nmi_mask = 1'b1;
        tmr_oc_en = 5'h00; gp_data = 8'h01; gp_dir = 8'h01;
        repeat (4) settle();
        check8("R7 stays locked after mask set", {pin_oe[0], pin_out[0]}, 8'h00);

        // R8: largest package ignores lock
        @(negedge clk);
        pkg_sel = 2'd2;
        #1;
        check8("R8 large pkg gp on pin0", {pin_oe[0], pin_out[0]}, 8'h03);
        @(negedge clk);
        tmr_oc_en = 5'h01; tmr_lvl = 5'h00;
        #1;
        check8("R8 large pkg timer0 over gp", {pin_oe[0], pin_out[0]}, 8'h02);

        // R11: code 3 honours the lock like code 1
        @(negedge clk);
        pkg_sel = 2'd3;
        #1;
        check8("R11 code 3 locked pin0", {pin_oe[0], pin_out[0]}, 8'h00);

        // R7: reset clears the lock
        @(negedge clk);
        pkg_sel = 2'd1; tmr_oc_en = 5'h00;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) settle();
        check8("R7 lock cleared by reset", {pin_oe[0], pin_out[0]}, 8'h03);

        // R6: mask low right after reset counts as a fall
        @(negedge clk);
        rst_n = 1'b0;
        nmi_mask = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check8("R6 no lock during first cycle", {pin_oe[0], pin_out[0]}, 8'h03);
        settle();
        check8("R6 lock after reset with mask low", {pin_oe[0], pin_out[0]}, 8'h00);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule